// File: doc/BRIEF.md
# Cascadable Serial Configuration Bit Streamer

This block is the read side of a serial configuration memory. A programmable device acting as configuration master supplies the clock and two control lines, and the block streams its stored bitstream back one bit per clock. Storage is an array of words with a parameterized width and depth. The first `TOTAL_BITS` bit positions make up the configuration image. Any rows after the image are spare storage and are never streamed.

A single control input does two jobs. While it is low, it clears the position counters and keeps the data line quiet. While it is high, it enables the output. An active-low chip enable gates both the counters and the output driver. When the chip enable is high, the block sits in standby and holds its position.

When the last image bit has been sent, an active-low cascade output drops and the block releases the data line, so that a following memory in a chain can take over. The cascade output stays low until the next low level on the reset/enable input.

A mode input selects programming mode when it is low. In that mode the readout path is idle and a simple synchronous load port writes whole rows. The tri-state data pin is modelled as a data bit plus a drive-enable flag.

Top module: `cfg_stream_rom`

## Requirements
- R1: While `rst_oe` is low, the row and bit counters are cleared at once, without waiting for a clock, and `cas_n` returns high. `dout_en` is low whatever the level of `ce_n`.
- R2: `dout_en` is 1 exactly when all of the following hold: `rst_oe` is 1, `ce_n` is 0, `ser_en` is 1, and the image is not yet exhausted. While `dout_en` is 1, `dout` carries the bit at the current position. While `dout_en` is 0, `dout` is 0. The bit at position 0 appears as soon as the output becomes enabled after a reset, before any clock edge.
- R3: While `ce_n` is 1, clock edges leave the position unchanged and `dout_en` stays 0, whatever the level of `rst_oe`.
- R4: Each rising clock edge advances the position by one bit while the conditions of R2 hold. Position p is bit (p mod WORD_W) of row (p / WORD_W), with bit 0 of each row sent first and row 0 first.
- R5: The rising edge that advances past position `TOTAL_BITS`-1 drives `cas_n` to 0. From then on, `dout_en` is 0 and the position no longer moves. `cas_n` stays 0 until `rst_oe` goes low.
- R6: The reset state has `cas_n` = 1, `dout_en` = 0 and the position at 0. Once the output is enabled, the first bit streamed is bit 0 of row 0.
- R7: While `ser_en` is 0, `dout_en` is 0 and the position is frozen, whatever the level of `ce_n`.
- R8: On a rising clock edge with `load_en` = 1 and `ser_en` = 0, row `load_addr` takes the value `load_data`. When `ser_en` = 1, `load_en` has no effect on the stored data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock; counters and the load port act on its rising edge |
| rst_oe | input | 1 | Low: clears the counters at once; high: enables the output |
| ce_n | input | 1 | Active-low chip enable; high selects standby |
| ser_en | input | 1 | High: read mode; low: programming mode |
| load_en | input | 1 | Row write strobe, honoured only in programming mode |
| load_addr | input | $clog2(ROWS) | Row to write |
| load_data | input | WORD_W | Row contents to write |
| dout | output | 1 | Serial data bit; 0 when not driven |
| dout_en | output | 1 | Data pin drive enable; 0 means high impedance |
| cas_n | output | 1 | Active-low cascade enable; low once the image has been sent |

## Verification
The assertions assume that `rst_oe`, `ce_n` and `ser_en` change only away from the rising clock edge. They also assume that any low pulse on `rst_oe` lasts at least one full clock period, so the clocked checks can see it through `$past`. The bench satisfies both by changing every input at the falling edge and holding `rst_oe` low for whole cycles.

The bench then pauses the stream in several ways: with `ce_n` high, with `ser_en` low, and with a reset applied while `ce_n` is high. It runs the stream past the end of the image, and it writes rows in read mode, which must have no effect.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    typedef enum logic [1:0] {
        MODE_CLEAR   = 2'd0,
        MODE_PROG    = 2'd1,
        MODE_STANDBY = 2'd2,
        MODE_READ    = 2'd3
    } mode_e;

    // Control priority: clear beats programming, programming beats chip enable.
    function automatic mode_e mode_of(input logic rst_oe, input logic ser_en, input logic ce_n);
        if (!rst_oe)     return MODE_CLEAR;
        else if (!ser_en) return MODE_PROG;
        else if (ce_n)   return MODE_STANDBY;
        else             return MODE_READ;
    endfunction

endpackage

// File: rtl/cfs_bit_array.sv
module cfs_bit_array #(
    parameter int WORD_W = 8,
    parameter int ROWS   = 64,
    parameter int ROW_W  = 7,
    parameter int BIT_W  = 3
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(ROWS)-1:0]  wr_row,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic [ROW_W-1:0]         rd_row,
    input  logic [BIT_W-1:0]         rd_bit,
    output logic                     rd_val
);
    localparam int NBITS = WORD_W * ROWS;
    localparam int IDX_W = $clog2(NBITS + 1);

    logic [NBITS-1:0] flat;
    logic [IDX_W-1:0] rd_idx;

    genvar r;
    generate
        for (r = 0; r < ROWS; r++) begin : g_row
            logic [WORD_W-1:0] word_q;
            always_ff @(posedge clk) begin
                if (wr_en && (wr_row == r[$clog2(ROWS)-1:0])) begin
                    word_q <= wr_data;
                end
            end
            assign flat[r*WORD_W +: WORD_W] = word_q;
        end
    endgenerate

    always_comb begin
        rd_idx = IDX_W'(rd_row) * IDX_W'(WORD_W) + IDX_W'(rd_bit);
        if (rd_idx < IDX_W'(NBITS)) begin
            rd_val = flat[rd_idx];
        end else begin
            rd_val = 1'b0;
        end
    end

endmodule

// File: rtl/cfs_addr_ctr.sv
module cfs_addr_ctr
    import cfs_pkg::*;
#(
    parameter int WORD_W     = 8,
    parameter int ROWS       = 64,
    parameter int TOTAL_BITS = 300,
    parameter int ROW_W      = 7,
    parameter int BIT_W      = 3
) (
    input  logic             clk,
    input  logic             rst_oe,
    input  mode_e            mode,
    output logic [ROW_W-1:0] row_o,
    output logic [BIT_W-1:0] bit_o,
    output logic             done_o
);
    localparam int LAST_ROW = (TOTAL_BITS - 1) / WORD_W;
    localparam int LAST_BIT = (TOTAL_BITS - 1) % WORD_W;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [BIT_W-1:0] bpos;
        logic             done;
    } ctr_t;

    ctr_t st_d, st_q;
    logic at_last;
    logic at_wrap;

    always_comb begin
        st_d    = st_q;
        at_last = (st_q.row == ROW_W'(LAST_ROW)) && (st_q.bpos == BIT_W'(LAST_BIT));
        at_wrap = (st_q.bpos == BIT_W'(WORD_W - 1));
        if (mode == MODE_READ && !st_q.done) begin
            if (at_wrap) begin
                st_d.bpos = '0;
                st_d.row  = st_q.row + 1'b1;
            end else begin
                st_d.bpos = st_q.bpos + 1'b1;
            end
            if (at_last) begin
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_oe) begin
        if (!rst_oe) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign row_o  = st_q.row;
    assign bit_o  = st_q.bpos;
    assign done_o = st_q.done;

endmodule

// File: rtl/cfs_out_drv.sv
module cfs_out_drv
    import cfs_pkg::*;
(
    input  mode_e mode,
    input  logic  done,
    input  logic  bit_val,
    output logic  dout,
    output logic  dout_en,
    output logic  cas_n
);
    always_comb begin
        dout_en = (mode == MODE_READ) && !done;
        dout    = dout_en ? bit_val : 1'b0;
        cas_n   = !done;
    end
endmodule

// File: rtl/cfg_stream_rom.sv
module cfg_stream_rom
    import cfs_pkg::*;
#(
    parameter int WORD_W     = 8,
    parameter int ROWS       = 64,
    parameter int TOTAL_BITS = 300
) (
    input  logic                    clk,
    input  logic                    rst_oe,
    input  logic                    ce_n,
    input  logic                    ser_en,
    input  logic                    load_en,
    input  logic [$clog2(ROWS)-1:0] load_addr,
    input  logic [WORD_W-1:0]       load_data,
    output logic                    dout,
    output logic                    dout_en,
    output logic                    cas_n
);
    localparam int ROW_W = $clog2(ROWS + 1);
    localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    mode_e            mode;
    logic [ROW_W-1:0] row_w;
    logic [BIT_W-1:0] bit_w;
    logic             done_w;
    logic             bit_val;
    logic             wr_en;

    assign mode  = mode_of(rst_oe, ser_en, ce_n);
    assign wr_en = load_en && !ser_en;

    cfs_addr_ctr #(
        .WORD_W(WORD_W), .ROWS(ROWS), .TOTAL_BITS(TOTAL_BITS),
        .ROW_W(ROW_W), .BIT_W(BIT_W)
    ) u_ctr (
        .clk(clk), .rst_oe(rst_oe), .mode(mode),
        .row_o(row_w), .bit_o(bit_w), .done_o(done_w)
    );

    cfs_bit_array #(
        .WORD_W(WORD_W), .ROWS(ROWS), .ROW_W(ROW_W), .BIT_W(BIT_W)
    ) u_arr (
        .clk(clk), .wr_en(wr_en), .wr_row(load_addr), .wr_data(load_data),
        .rd_row(row_w), .rd_bit(bit_w), .rd_val(bit_val)
    );

    cfs_out_drv u_out (
        .mode(mode), .done(done_w), .bit_val(bit_val),
        .dout(dout), .dout_en(dout_en), .cas_n(cas_n)
    );

endmodule

// File: rtl/cfs_chk.sv
module cfs_chk #(
    parameter int WORD_W     = 8,
    parameter int TOTAL_BITS = 300,
    parameter int ROW_W      = 7,
    parameter int BIT_W      = 3
) (
    input logic             clk,
    input logic             rst_oe,
    input logic             ce_n,
    input logic             ser_en,
    input logic             dout_en,
    input logic             cas_n,
    input logic [ROW_W-1:0] row,
    input logic [BIT_W-1:0] bpos
);
    int pos;
    assign pos = int'(row) * WORD_W + int'(bpos);

    // R1
    cleared_on_release_chk: assert property (@(posedge clk) disable iff (!rst_oe)
        $rose(rst_oe) |-> (pos == 0) && cas_n);

    // R4
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_oe)
        $past(rst_oe && !ce_n && ser_en && cas_n) |-> pos == $past(pos) + 1);

    // R3
    standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_oe)
        ($past(rst_oe) && $past(ce_n)) |-> $stable(row) && $stable(bpos));

    // R7
    prog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_oe)
        !ser_en |-> !dout_en);

    // R5
    cascade_hold_chk: assert property (@(posedge clk) disable iff (!rst_oe)
        !cas_n |=> !cas_n);

    // R5
    cascade_release_chk: assert property (@(posedge clk) disable iff (!rst_oe)
        !cas_n |-> !dout_en && (pos == TOTAL_BITS));

    // R5
    pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_oe)
        pos <= TOTAL_BITS);

endmodule

bind cfg_stream_rom cfs_chk #(
    .WORD_W(WORD_W), .TOTAL_BITS(TOTAL_BITS), .ROW_W(ROW_W), .BIT_W(BIT_W)
) u_chk (
    .clk(clk), .rst_oe(rst_oe), .ce_n(ce_n), .ser_en(ser_en),
    .dout_en(dout_en), .cas_n(cas_n), .row(row_w), .bpos(bit_w)
);

// File: tb/test_cfg_stream_rom.sv
`timescale 1ns/1ps
module test_cfg_stream_rom;
    localparam int WORD_W     = 8;
    localparam int ROWS       = 64;
    localparam int TOTAL_BITS = 300;
    localparam int AW         = $clog2(ROWS);

    logic clk = 1'b0;
    logic rst_oe = 1'b0;
    logic ce_n = 1'b1;
    logic ser_en = 1'b1;
    logic load_en = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [WORD_W-1:0] load_data = '0;
    logic dout, dout_en, cas_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit ref_bits [ROWS*WORD_W];
    int m_pos = 0;
    bit m_done = 1'b0;

    always #5 clk = ~clk;

    cfg_stream_rom #(.WORD_W(WORD_W), .ROWS(ROWS), .TOTAL_BITS(TOTAL_BITS)) i_cfg_stream_rom (
        .clk(clk), .rst_oe(rst_oe), .ce_n(ce_n), .ser_en(ser_en),
        .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
        .dout(dout), .dout_en(dout_en), .cas_n(cas_n)
    );

    function automatic logic [WORD_W-1:0] pat(input int a);
        return WORD_W'((a * 37 + 5) ^ (a << 3));
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b (pos %0d)", tag, what, act, exp, m_pos);
        end
    endtask

    task automatic cyc(input string tag, input logic r, input logic c, input logic s,
                       input logic le, input int la, input logic [WORD_W-1:0] ld);
        bit en;
        @(negedge clk);
        rst_oe = r; ce_n = c; ser_en = s;
        load_en = le; load_addr = AW'(la); load_data = ld;
        if (!r) begin
            m_pos = 0;
            m_done = 1'b0;
        end
        #1;
        en = r && !c && s && !m_done;
        check(tag, "dout_en", dout_en, en);
        check(tag, "cas_n", cas_n, !m_done);
        check(tag, "dout", dout, en ? ref_bits[m_pos] : 1'b0);
        @(posedge clk);
        if (le && !s) begin
            for (int b = 0; b < WORD_W; b++) ref_bits[la*WORD_W + b] = ld[b];
        end
        if (en) begin
            m_pos++;
            if (m_pos == TOTAL_BITS) m_done = 1'b1;
        end
    endtask

    task automatic run(input string tag, input int n, input logic r, input logic c, input logic s);
        for (int i = 0; i < n; i++) cyc(tag, r, c, s, 1'b0, 0, '0);
    endtask

    initial begin
        #(20000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R6, R1: reset state
        run("R6", 3, 1'b0, 1'b0, 1'b1);
        // R8, R7: load every row in programming mode with ce_n low
        for (int a = 0; a < ROWS; a++) cyc("R7", 1'b1, 1'b0, 1'b0, 1'b1, a, pat(a));
        // R8: writes in read mode must not change row 0 or row 1
        cyc("R8", 1'b1, 1'b1, 1'b1, 1'b1, 0, ~pat(0));
        cyc("R8", 1'b1, 1'b1, 1'b1, 1'b1, 1, ~pat(1));
        // R3: standby, no movement
        run("R3", 5, 1'b1, 1'b1, 1'b1);
        // R2, R4, R8: stream first rows
        run("R4", 20, 1'b1, 1'b0, 1'b1);
        // R3: pause with ce_n high, then resume
        run("R3", 4, 1'b1, 1'b1, 1'b1);
        run("R4", 10, 1'b1, 1'b0, 1'b1);
        // R7: programming mode mid-stream, ce_n low
        run("R7", 3, 1'b1, 1'b0, 1'b0);
        run("R4", 6, 1'b1, 1'b0, 1'b1);
        // R1: reset while chip enable is high
        run("R1", 2, 1'b0, 1'b1, 1'b1);
        run("R1", 1, 1'b1, 1'b1, 1'b1);
        // R6, R2: full stream to the end
        run("R2", TOTAL_BITS - 40, 1'b1, 1'b0, 1'b1);
        run("R3", 2, 1'b1, 1'b1, 1'b1);
        run("R5", 50, 1'b1, 1'b0, 1'b1);
        // R5: cascade stays low in standby and programming mode
        run("R5", 3, 1'b1, 1'b1, 1'b1);
        run("R5", 3, 1'b1, 1'b0, 1'b0);
        // R1, R5: reset pulse brings cascade back high, stream restarts
        run("R1", 1, 1'b0, 1'b0, 1'b1);
        run("R6", 12, 1'b1, 1'b0, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule